// File: doc/BRIEF.md
# Masked CAN Acceptance Filter

This block decides whether one receive buffer should take a CAN frame. It combines the received identifier, the format flag (extended or standard), the remote-request flag and the first two payload bytes into a comparison. Each of these is set against a per-buffer code word under a per-buffer mask. A mask bit of 1 marks its position as don't-care. A mask bit of 0 requires the incoming bit to equal the code bit at that position.

The header comparison uses a 32-bit word. Its upper 29 bits carry the identifier, left-aligned. Bit 2 carries the format flag, bit 1 carries the remote-request flag, and bit 0 is unused. A second mask/code pair covers the first two payload bytes. The block registers a single accept flag one clock after a frame-valid strobe. It also registers the identifier, aligned the way the buffer stores it. Reception, storage and arbitration between buffers are handled elsewhere.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is high and on the first cycle after it, `acc_out` is 0 and `id_word` is 0.
- R2: Header word layout: identifier in bits 31:3, the format flag (1 = extended) in bit 2, the remote-request flag in bit 1. Where `hdr_mask` bit is 0 and the header bit differs from `hdr_code`, the frame is rejected.
- R3: A mask bit of 1 makes its position don't-care. All-ones header and data masks accept every valid frame.
- R4: Bit 0 of `hdr_mask` and `hdr_code` has no effect on acceptance.
- R5: For an extended frame (`frm_ext`=1), `id_word` = {`frm_id`[28:0], 3'b000}.
- R6: For a standard frame, `id_word` = {`frm_id`[10:0], 21'b0}. `frm_id` bits 28:11 have no effect on acceptance or on `id_word`.
- R7: Data filtering: payload byte 1 is compared under `dat_mask`/`dat_code` bits 15:8 and byte 2 under bits 7:0, with the same mask polarity.
- R8: Absent payload bytes count as matching. For a frame with `frm_rtr`=1, or with `frm_dlc`=0, neither byte is checked. With `frm_dlc`=1, only byte 1 is checked. For any `frm_dlc` of 2 or more, including 9 to 15, both bytes are checked.
- R9: `acc_out` is registered. It reflects the frame presented with `frm_vld`=1 on the previous clock edge, and it is 0 after any edge where `frm_vld` was 0.
- R10: `id_word` loads only on edges where `frm_vld`=1 and otherwise holds its value.
- R11: A frame is accepted only when both the header match and the data match hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_vld | input | 1 | Frame fields below are valid this cycle |
| frm_ext | input | 1 | 1 = extended 29-bit identifier, 0 = standard 11-bit |
| frm_rtr | input | 1 | Remote-request flag of the frame |
| frm_id | input | 29 | Identifier, right-aligned (standard uses bits 10:0) |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 16 | Payload byte 1 in 15:8, byte 2 in 7:0 |
| hdr_mask | input | 32 | Header mask, 1 = don't care |
| hdr_code | input | 32 | Header code word |
| dat_mask | input | 16 | Data mask, 1 = don't care |
| dat_code | input | 16 | Data code word |
| acc_out | output | 1 | Registered accept result |
| id_word | output | 32 | Registered left-aligned identifier |

## Verification
The properties assume that frame fields and filter registers are stable and known in any cycle where `frm_vld` is high. They also assume that reset is held for at least one edge before traffic begins. The bench drives every input only on the falling clock edge and holds reset for several cycles. It keeps the filter registers constant across each strobe, so every edge sees one consistent frame and filter pair. Random frames use mostly set mask bits, so both accepts and rejects occur often.

// File: rtl/canf_pkg.sv
package canf_pkg;
    localparam int ID_EXT_W   = 29;
    localparam int ID_STD_W   = 11;
    localparam int HDR_W      = 32;
    localparam int HDR_ID_LSB = HDR_W - ID_EXT_W;
    localparam int EXT_BIT    = 2;
    localparam int RTR_BIT    = 1;
    localparam int BYTE_W     = 8;
    localparam int FILT_BYTES = 2;
    localparam int DAT_W      = BYTE_W * FILT_BYTES;
    localparam int DLC_W      = 4;
    localparam logic [HDR_W-1:0] HDR_USED = ~HDR_W'(1);

    typedef struct packed {
        logic                ext;
        logic                rtr;
        logic [ID_EXT_W-1:0] id;
        logic [DLC_W-1:0]    dlc;
        logic [DAT_W-1:0]    data;
    } frame_t;

    typedef struct packed {
        logic [HDR_W-1:0] mask;
        logic [HDR_W-1:0] code;
    } hdr_filt_t;

    typedef struct packed {
        logic [DAT_W-1:0] mask;
        logic [DAT_W-1:0] code;
    } dat_filt_t;

    function automatic logic [HDR_W-1:0] left_align_id(input logic ext,
                                                        input logic [ID_EXT_W-1:0] id);
        logic [HDR_W-1:0] w;
        if (ext) w = {id, {HDR_ID_LSB{1'b0}}};
        else     w = {id[ID_STD_W-1:0], {(HDR_W-ID_STD_W){1'b0}}};
        return w;
    endfunction
endpackage

// File: rtl/canf_hdr_word.sv
module canf_hdr_word
    import canf_pkg::*;
(
    input  frame_t           frm,
    output logic [HDR_W-1:0] id_al,
    output logic [HDR_W-1:0] hdr
);
    always_comb begin
        id_al        = left_align_id(frm.ext, frm.id);
        hdr          = id_al;
        hdr[EXT_BIT] = frm.ext;
        hdr[RTR_BIT] = frm.rtr;
        hdr[0]       = 1'b0;
    end
endmodule

// File: rtl/canf_hdr_cmp.sv
module canf_hdr_cmp
    import canf_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    input  hdr_filt_t        flt,
    output logic             hit
);
    logic [HDR_W-1:0] diff;
    always_comb begin
        diff = (hdr ^ flt.code) & ~flt.mask & HDR_USED;
        hit  = ~|diff;
    end
endmodule

// File: rtl/canf_data_cmp.sv
module canf_data_cmp
    import canf_pkg::*;
(
    input  frame_t    frm,
    input  dat_filt_t flt,
    output logic      hit
);
    logic [FILT_BYTES-1:0] byte_ok;

    for (genvar b = 0; b < FILT_BYTES; b++) begin : g_byte
        localparam int HI = DAT_W - 1 - b * BYTE_W;
        localparam int LO = HI - BYTE_W + 1;
        logic present;
        logic [BYTE_W-1:0] diff;
        always_comb begin
            present    = !frm.rtr && (frm.dlc > DLC_W'(b));
            diff       = (frm.data[HI:LO] ^ flt.code[HI:LO]) & ~flt.mask[HI:LO];
            byte_ok[b] = !present || (diff == '0);
        end
    end

    assign hit = &byte_ok;
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import canf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_vld,
    input  logic             frm_ext,
    input  logic             frm_rtr,
    input  logic [28:0]      frm_id,
    input  logic [3:0]       frm_dlc,
    input  logic [15:0]      frm_data,
    input  logic [31:0]      hdr_mask,
    input  logic [31:0]      hdr_code,
    input  logic [15:0]      dat_mask,
    input  logic [15:0]      dat_code,
    output logic             acc_out,
    output logic [31:0]      id_word
);
    frame_t           frm;
    hdr_filt_t        hflt;
    dat_filt_t        dflt;
    logic [HDR_W-1:0] id_al;
    logic [HDR_W-1:0] hdr;
    logic             hdr_hit;
    logic             dat_hit;

    always_comb begin
        frm.ext   = frm_ext;
        frm.rtr   = frm_rtr;
        frm.id    = frm_id;
        frm.dlc   = frm_dlc;
        frm.data  = frm_data;
        hflt.mask = hdr_mask;
        hflt.code = hdr_code;
        dflt.mask = dat_mask;
        dflt.code = dat_code;
    end

    canf_hdr_word u_word (.frm(frm), .id_al(id_al), .hdr(hdr));
    canf_hdr_cmp  u_hcmp (.hdr(hdr), .flt(hflt), .hit(hdr_hit));
    canf_data_cmp u_dcmp (.frm(frm), .flt(dflt), .hit(dat_hit));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out <= 1'b0;
            id_word <= '0;
        end else begin
            acc_out <= frm_vld && hdr_hit && dat_hit;
            if (frm_vld) id_word <= id_al;
        end
    end
endmodule

// File: rtl/canf_chk.sv
module canf_chk (
    input logic        clk,
    input logic        rst,
    input logic        frm_vld,
    input logic        frm_ext,
    input logic        frm_rtr,
    input logic [28:0] frm_id,
    input logic [3:0]  frm_dlc,
    input logic [15:0] frm_data,
    input logic [31:0] hdr_mask,
    input logic [31:0] hdr_code,
    input logic [15:0] dat_mask,
    input logic [15:0] dat_code,
    input logic        acc_out,
    input logic [31:0] id_word
);
    // R9
    acc_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
        !frm_vld |=> !acc_out);
    // R10
    id_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frm_vld && !$past(rst)) |=> $stable(id_word));
    // R3
    all_dont_care_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && (&hdr_mask[31:1]) && (&dat_mask)) |=> acc_out);
    // R8
    rtr_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && frm_rtr && (&hdr_mask[31:1])) |=> acc_out);
    // R2
    ext_flag_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && !hdr_mask[2] && (hdr_code[2] != frm_ext)) |=> !acc_out);
    // R5
    ext_align_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && frm_ext) |=> (id_word == {$past(frm_id), 3'b000}));
    // R6
    std_align_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && !frm_ext) |=> (id_word == {$past(frm_id[10:0]), 21'b0}));
endmodule

bind can_accept_filter canf_chk u_chk (.*);

// File: tb/sim_can_accept_filter.sv
`timescale 1ns/1ps
module sim_can_accept_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_vld = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [15:0] frm_data = '0;
    logic [31:0] hdr_mask = '0, hdr_code = '0;
    logic [15:0] dat_mask = '0, dat_code = '0;
    logic        acc_out;
    logic [31:0] id_word;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";
    bit        m_acc = 1'b0;
    bit [31:0] m_id = '0;

    always #2.5 clk = ~clk;

    can_accept_filter u0 (.*);

    function automatic bit [31:0] ref_id(bit ext, bit [28:0] id);
        bit [31:0] w = '0;
        for (int i = 3; i < 32; i++) begin
            if (ext) w[i] = id[i-3];
            else if (i >= 21) w[i] = id[i-21];
        end
        return w;
    endfunction

    function automatic bit ref_accept();
        bit [31:0] w = ref_id(frm_ext, frm_id);
        int nbytes;
        w[2] = frm_ext;
        w[1] = frm_rtr;
        for (int i = 1; i < 32; i++)
            if (!hdr_mask[i] && (w[i] != hdr_code[i])) return 1'b0;
        nbytes = frm_rtr ? 0 : (frm_dlc > 2 ? 2 : int'(frm_dlc));
        for (int b = 0; b < nbytes; b++)
            for (int k = 0; k < 8; k++) begin
                int p = 15 - 8*b - k;
                if (!dat_mask[p] && (frm_data[p] != dat_code[p])) return 1'b0;
            end
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 1'b0;
            m_id  = '0;
            chk_on = 1'b1;
        end else begin
            m_acc = frm_vld && ref_accept();
            if (frm_vld) m_id = ref_id(frm_ext, frm_id);
        end
    end

    always @(negedge clk) if (chk_on && !done) begin
        checks += 2;
        if (acc_out !== m_acc) begin
            errors++;
            $display("FAIL %s acc_out=%0b expected=%0b", cur_req, acc_out, m_acc);
        end
        if (id_word !== m_id) begin
            errors++;
            $display("FAIL %s id_word=%h expected=%h", cur_req, id_word, m_id);
        end
    end

    task automatic send(string req, bit ext, bit rtr, bit [28:0] id, bit [3:0] dlc,
                        bit [15:0] d, bit [31:0] hm, bit [31:0] hc,
                        bit [15:0] dm, bit [15:0] dc);
        @(negedge clk);
        cur_req = req;
        frm_vld = 1; frm_ext = ext; frm_rtr = rtr; frm_id = id; frm_dlc = dlc;
        frm_data = d; hdr_mask = hm; hdr_code = hc; dat_mask = dm; dat_code = dc;
        @(negedge clk);
        frm_vld = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        cur_req = "R1";
        rst = 0;
        @(negedge clk);
        // R2 R11: exact extended match with all-zero masks accepts
        send("R2", 1, 0, 29'h1ABCDEF1, 8, 16'hA55A, 32'h0, {29'h1ABCDEF1, 3'b100}, 16'h0, 16'hA55A);
        // R2: format flag mismatch rejects
        send("R2", 0, 0, 29'h1ABCDEF1, 8, 16'hA55A, 32'h0, {29'h1ABCDEF1, 3'b100}, 16'h0, 16'hA55A);
        // R2: rtr flag mismatch rejects
        send("R2", 1, 1, 29'h1ABCDEF1, 8, 16'hA55A, 32'h0, {29'h1ABCDEF1, 3'b100}, 16'h0, 16'hA55A);
        // R3: differing id bit under a set mask bit accepts
        send("R3", 1, 0, 29'h1ABCDEF0, 8, 16'hA55A, 32'h0000_0008, {29'h1ABCDEF1, 3'b100}, 16'h0, 16'hA55A);
        // R3: all-ones masks accept anything
        send("R3", 0, 0, 29'h0000_0123, 5, 16'h1234, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 16'h0);
        // R4: bit 0 differs with mask 0, still accepted
        send("R4", 1, 0, 29'h0000_0055, 2, 16'h0102, 32'h0, {29'h55, 3'b101}, 16'h0, 16'h0102);
        // R5: extended alignment
        send("R5", 1, 0, 29'h1FFF_FFFF, 0, 16'h0, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 16'h0);
        // R6: standard alignment, upper id bits ignored for acceptance and id_word
        send("R6", 0, 0, 29'h1555_57FF, 0, 16'h0, 32'h0, {11'h7FF, 21'b0}, 16'h0, 16'h0);
        // R7: byte 1 mismatch rejects, byte 2 mismatch under mask accepts
        send("R7", 1, 0, 29'h42, 8, 16'hFF00, 32'hFFFF_FFFF, 32'h0, 16'h0000, 16'h0000);
        send("R7", 1, 0, 29'h42, 8, 16'h00FF, 32'hFFFF_FFFF, 32'h0, 16'h00FF, 16'h0000);
        send("R7", 1, 0, 29'h42, 8, 16'h00FF, 32'hFFFF_FFFF, 32'h0, 16'hFF00, 16'h0000);
        // R8: absent bytes
        send("R8", 1, 0, 29'h42, 0, 16'hFFFF, 32'hFFFF_FFFF, 32'h0, 16'h0, 16'h0);
        send("R8", 1, 0, 29'h42, 1, 16'h00FF, 32'hFFFF_FFFF, 32'h0, 16'h0, 16'h0);
        send("R8", 1, 0, 29'h42, 1, 16'hFF00, 32'hFFFF_FFFF, 32'h0, 16'h0, 16'h0);
        send("R8", 1, 0, 29'h42, 15, 16'h00FF, 32'hFFFF_FFFF, 32'h0, 16'h0, 16'h0);
        send("R8", 1, 1, 29'h42, 8, 16'hFFFF, 32'hFFFF_FFFF, 32'h0, 16'h0, 16'h0);
        // R9 R10: inputs change with no strobe; acc low, id held
        @(negedge clk);
        cur_req = "R10";
        frm_id = 29'h0BAD_BEEF; frm_ext = 1; hdr_mask = '1; dat_mask = '1;
        repeat (4) @(negedge clk);
        // R11: random traffic, mostly-masked filters
        cur_req = "R11";
        for (int n = 0; n < 400; n++) begin
            bit [28:0] id = 29'($urandom);
            bit [31:0] hc = $urandom;
            bit [15:0] dc = 16'($urandom);
            send("R11", 1'($urandom), 1'($urandom_range(0, 3) == 0), id,
                 4'($urandom), 16'($urandom),
                 $urandom | $urandom | $urandom, hc,
                 16'($urandom | $urandom), dc);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule